// File: doc/BRIEF.md
# NMI Source Status Aggregator

This block gathers five non-maskable event sources into a sticky status byte and drives a single NMI line towards the CPU. The five sources are an external pin, oscillation-stop detection, a watchdog underflow or refresh error, and two voltage monitors. Each source delivers one-cycle pulses. A pulse is recorded only when that source's enable bit is set. Once recorded, the bit stays set until software clears it.

Software sees three registers through a small synchronous write port and a combinational read port. The status byte is read-only. The enable byte can be set but never cleared. The clear byte is write-one-to-clear. The block also resolves the highest-priority pending source into a three-bit index, so an exception handler can dispatch without scanning the byte.

The NMI line is produced by a two-state machine. `LINE_QUIET` moves to `LINE_RAISED` when any enabled status bit is pending. `LINE_RAISED` moves back to `LINE_QUIET` once nothing is pending. Each state holds while its condition is unchanged. The output is high exactly in `LINE_RAISED`.

Top module: `nmi_event_aggregator`

## Requirements
- R1: After reset the status and enable bytes read 0x00, `pend_idx` is 5 and `nmi_out` is 0.
- R2: The status byte and the enable byte use one layout: bit 0 pin, bit 1 oscillation stop, bit 3 watchdog, bit 4 voltage monitor 1, bit 5 voltage monitor 2. Bits 2, 6 and 7 always read 0. `src_pulse` index order is pin=0, oscillation=1, watchdog=2, monitor1=3, monitor2=4.
- R3: A pulse on an enabled source sets its status bit at the next clock edge. The bit then stays set until a clear write hits it.
- R4: A pulse on a source whose enable bit is 0 before the edge leaves its status unchanged. This includes a pulse in the same cycle as the write that enables the source.
- R5: An enable bit is set by writing 1 at its position to address 1. Writing 0 never clears it.
- R6: Writing 1 at a source's position to address 2 clears only that status bit. Zeros in the clear write have no effect.
- R7: When a set pulse and a clear write hit the same status bit in the same cycle, the bit stays set.
- R8: `pend_idx` gives the lowest-numbered pending source: pin 0, oscillation 1, watchdog 2, monitor1 3, monitor2 4.
- R9: `pend_idx` equals 5 whenever no status bit is set.
- R10: `nmi_out` in the cycle after edge k equals the OR of the enabled status bits as they stood before edge k, which is one register stage.
- R11: Address 0 is read-only: writes to it change nothing. Addresses 2 and 3 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 5 | One-cycle event pulses, one per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 status, 1 enable, 2 clear |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| pend_idx | output | 3 | Highest-priority pending source, 5 when none |
| nmi_out | output | 1 | Registered NMI request |

## Verification
Two events can land on one status bit in the same cycle: the source's set pulse and the software clear write. The bench provokes this on purpose, both on the same bit and on different bits, and also mixes the two freely in a long pseudo-random phase. A behavioural model applies set-over-clear for every bit on every clock. The status readback, the index and the NMI line are then compared against it. A second collision is an enable write that coincides with the first pulse of that source, and the model expects that pulse to be dropped.

// File: rtl/nmi_agg_pkg.sv
package nmi_agg_pkg;
    localparam int unsigned NSRC     = 5;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned GAP_BIT  = 2;
    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned IDX_W    = $clog2(NSRC + 1);

    typedef enum logic [ADDR_W-1:0] {
        A_STAT  = 2'd0,
        A_EN    = 2'd1,
        A_CLR   = 2'd2,
        A_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;
endpackage

// File: rtl/nmi_src_cell.sv
module nmi_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    input  logic en_set,
    input  logic clr,
    output logic en_q,
    output logic stat_q
);
    // enable is sticky-one; pulse is gated by the enable held before this edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            en_q   <= en_q | en_set;
            stat_q <= (pulse & en_q) | (stat_q & ~clr);
        end
    end
endmodule

// File: rtl/nmi_prio_enc.sv
module nmi_prio_enc #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [IDX_W-1:0]   idx
);
    localparam logic [IDX_W-1:0] NONE = IDX_W'(NUM_SRC);

    always_comb begin
        idx = NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/nmi_line_fsm.sv
module nmi_line_fsm
    import nmi_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    output logic nmi
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending)  state_d = LINE_RAISED;
            LINE_RAISED: if (!pending) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        nmi = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/nmi_event_aggregator.sv
module nmi_event_aggregator
    import nmi_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = nmi_agg_pkg::NSRC,
    parameter int unsigned DATA_W  = nmi_agg_pkg::BYTE_W,
    parameter int unsigned GAP_POS = nmi_agg_pkg::GAP_BIT,
    localparam int unsigned IW     = $clog2(NUM_SRC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_pulse,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [IW-1:0]         pend_idx,
    output logic                  nmi_out
);
    logic [NUM_SRC-1:0] en_wr_bit, clr_bit, en_vec, stat_vec;
    logic [DATA_W-1:0]  stat_byte, en_byte;
    logic               wr_en_reg, wr_clr_reg;

    assign wr_en_reg  = reg_wr && (reg_addr == A_EN);
    assign wr_clr_reg = reg_wr && (reg_addr == A_CLR);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned P = (i < GAP_POS) ? i : i + 1;
        assign en_wr_bit[i] = wr_en_reg  & reg_wdata[P];
        assign clr_bit[i]   = wr_clr_reg & reg_wdata[P];

        nmi_src_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .pulse  (src_pulse[i]),
            .en_set (en_wr_bit[i]),
            .clr    (clr_bit[i]),
            .en_q   (en_vec[i]),
            .stat_q (stat_vec[i])
        );
    end

    // sparse byte packing, the gap and upper bits stay zero
    always_comb begin
        stat_byte = '0;
        en_byte   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i < GAP_POS) begin
                stat_byte[i] = stat_vec[i];
                en_byte[i]   = en_vec[i];
            end else begin
                stat_byte[i+1] = stat_vec[i];
                en_byte[i+1]   = en_vec[i];
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(reg_addr))
            A_STAT:  reg_rdata = stat_byte;
            A_EN:    reg_rdata = en_byte;
            default: reg_rdata = '0;
        endcase
    end

    nmi_prio_enc #(.NUM_SRC(NUM_SRC), .IDX_W(IW)) i_prio (
        .req (stat_vec),
        .idx (pend_idx)
    );

    nmi_line_fsm i_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|(stat_vec & en_vec)),
        .nmi     (nmi_out)
    );
endmodule

// File: rtl/nmi_event_aggregator_chk.sv
module nmi_event_aggregator_chk #(
    parameter int unsigned NUM_SRC = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned GAP_POS = 2,
    parameter int unsigned IW      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_SRC-1:0] stat_vec,
    input logic [NUM_SRC-1:0] en_vec,
    input logic [IW-1:0]      pend_idx,
    input logic               nmi_out
);
    localparam logic [IW-1:0] NONE = IW'(NUM_SRC);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        localparam int unsigned P = (i < GAP_POS) ? i : i + 1;
        localparam logic [NUM_SRC-1:0] LOWER = NUM_SRC'((1 << i) - 1);
        localparam logic [IW-1:0] MY_IDX = IW'(i);

        p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (src_pulse[i] && en_vec[i]) |=> stat_vec[i]);
        p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_vec[i] && !(reg_wr && reg_addr == 2'd2 && reg_wdata[P])) |=> stat_vec[i]);
        p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat_vec[i] && !(src_pulse[i] && en_vec[i])) |=> !stat_vec[i]);
        p_en_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            en_vec[i] |=> en_vec[i]);
        p_idx_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_vec[i] && ((stat_vec & LOWER) == '0)) |-> (pend_idx == MY_IDX));
    end

    p_idx_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_vec == '0) |-> (pend_idx == NONE));
    p_nmi_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (nmi_out == $past(|(stat_vec & en_vec))));
endmodule

bind nmi_event_aggregator nmi_event_aggregator_chk #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .GAP_POS (GAP_POS),
    .IW      (IW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat_vec  (stat_vec),
    .en_vec    (en_vec),
    .pend_idx  (pend_idx),
    .nmi_out   (nmi_out)
);

// File: tb/test_nmi_event_aggregator.sv
module test_nmi_event_aggregator;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] src_pulse = '0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] pend_idx;
    logic       nmi_out;

    int errs = 0;
    int checks = 0;
    bit done = 0;
    bit [4:0] m_stat = '0, m_en = '0;
    bit m_nmi = 1'b0;

    always #2.5 clk = ~clk;

    nmi_event_aggregator i_nmi_event_aggregator (
        .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pend_idx(pend_idx), .nmi_out(nmi_out)
    );

    function automatic int bpos(int i);
        case (i)
            0: return 0;
            1: return 1;
            2: return 3;
            3: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int pack(bit [4:0] v);
        int r = 0;
        for (int i = 0; i < 5; i++) if (v[i]) r |= (1 << bpos(i));
        return r;
    endfunction

    function automatic int exp_idx();
        for (int i = 0; i < 5; i++) if (m_stat[i]) return i;
        return 5;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(logic [4:0] p, bit w, logic [1:0] a, logic [7:0] d, string req);
        bit [4:0] ns, ne;
        bit nn;
        int ei;
        src_pulse = p; reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        chk({req, " rdata"}, int'(reg_rdata),
            (a == 2'd0) ? pack(m_stat) : (a == 2'd1) ? pack(m_en) : 0);
        @(posedge clk);
        nn = |m_stat;
        for (int i = 0; i < 5; i++) begin
            ns[i] = (p[i] && m_en[i]) || (m_stat[i] && !(w && a == 2'd2 && d[bpos(i)]));
            ne[i] = m_en[i] || (w && a == 2'd1 && d[bpos(i)]);
        end
        m_stat = ns; m_en = ne; m_nmi = nn;
        @(negedge clk);
        src_pulse = '0; reg_wr = 1'b0;
        ei = exp_idx();
        chk((ei == 5) ? "R9 idx" : "R8 idx", int'(pend_idx), ei);
        chk("R10 nmi", int'(nmi_out), int'(m_nmi));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 idx", int'(pend_idx), 5);
        chk("R1 nmi", int'(nmi_out), 0);
        rst_n = 1'b1;
        cyc(5'b00000, 0, 2'd0, 8'h00, "R1 status");
        cyc(5'b00000, 0, 2'd1, 8'h00, "R1 enable");
        // pulses with every enable clear
        cyc(5'b11111, 0, 2'd0, 8'h00, "R4");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R4");
        // enable watchdog in the same cycle as its pulse: dropped
        cyc(5'b00100, 1, 2'd1, 8'h08, "R4");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R4");
        cyc(5'b00100, 0, 2'd1, 8'h00, "R5");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R3");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R2");
        // zero write does not drop enable, reserved bits read 0
        cyc(5'b00000, 1, 2'd1, 8'h00, "R5");
        cyc(5'b00000, 1, 2'd1, 8'hFF, "R5");
        cyc(5'b00000, 0, 2'd1, 8'h00, "R2");
        // priority ordering
        cyc(5'b10000, 0, 2'd0, 8'h00, "R8");
        cyc(5'b00001, 0, 2'd0, 8'h00, "R8");
        cyc(5'b01000, 0, 2'd0, 8'h00, "R2");
        cyc(5'b00000, 1, 2'd2, 8'h01, "R6");
        cyc(5'b00000, 1, 2'd2, 8'hC4, "R6");
        cyc(5'b00000, 1, 2'd2, 8'h08, "R6");
        cyc(5'b00000, 1, 2'd2, 8'h20, "R6");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R6");
        // set beats clear on same bit, clear other bit in parallel
        cyc(5'b01000, 1, 2'd2, 8'h10, "R7");
        cyc(5'b00010, 1, 2'd2, 8'h12, "R7");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R7");
        // status address is read-only, spare addresses read 0
        cyc(5'b00000, 1, 2'd0, 8'hFF, "R11");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R11");
        cyc(5'b00000, 0, 2'd2, 8'h00, "R11");
        cyc(5'b00000, 0, 2'd3, 8'h00, "R11");
        cyc(5'b00000, 1, 2'd2, 8'h3B, "R6");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R9");
        cyc(5'b00000, 0, 2'd0, 8'h00, "R10");
        // mixed pseudo-random traffic
        for (int n = 0; n < 400; n++) begin
            logic [4:0] p;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            p = (lf[2:0] == 3'd0) ? 5'(1 << (lf[6:4] % 5)) : 5'b0;
            if (lf[3:0] == 4'hF) p = p | 5'b00001;
            cyc(p, lf[9:8] == 2'd0, lf[11:10], lf[15:8], "R3 R6 R7");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule